// File: doc/BRIEF.md
# Synchronous Serial Clock Generator

This block drives the clock pin that goes with each frame a serial transmitter sends in synchronous mode. A frame is one start bit, eight or nine data bits and one stop bit. The transmitter supplies a frame-begin pulse and a half-bit timing strobe. From these the block places clock pulses on the data bits only. The start and stop bits never carry a pulse. Each pulse spans one bit period. Its two halves sit at opposite levels, so the capture edge always falls at the middle of a data bit.

Three live settings shape the waveform. Polarity sets the idle level. Phase picks which of the two transitions in a pulse is the capture edge. Enable decides whether the pin toggles at all. Two further settings are captured when a frame begins: the word length, and whether the final data bit gets a pulse. A one-cycle sample strobe marks every capture edge so that a receiver shifting in step can latch its input.

Top module: `sclk_gen`

## Requirements
- R1: After reset, and whenever no frame is running, `ck_out` equals `ck_pol` and `sample_stb` is 0.
- R2: With `ck_len_full` = 0, a frame gives (data bits − 1) pulses: 7 for `word_nine` = 0 (8 bits) and 8 for `word_nine` = 1 (9 bits). The last data bit gets no pulse.
- R3: With `ck_len_full` = 1, every data bit gets one pulse: 8 pulses for an 8-bit frame and 9 for a 9-bit frame.
- R4: `ck_out` stays at its idle level (`ck_pol`) through the start bit and the stop bit.
- R5: With `ck_pha` = 0, a pulsed bit holds the idle level in its first half and the active level (`~ck_pol`) in its second half. The first transition, at mid-bit, is the capture edge.
- R6: With `ck_pha` = 1, a pulsed bit holds the active level in its first half and the idle level in its second half. The second transition, at mid-bit, is the capture edge.
- R7: `ck_pol` = 1 makes the idle level high and the active level low. `ck_pol` = 0 gives the reverse.
- R8: While `ck_en` = 0, `ck_out` stays at `ck_pol` through a whole frame and `sample_stb` stays 0.
- R9: `sample_stb` is high for exactly one cycle at each capture edge, in the same cycle that `ck_out` makes its mid-bit transition. There is one strobe per pulse.
- R10: A `frame_start` that arrives while a frame is running is ignored. `word_nine` and `ck_len_full` are captured at `frame_start`, so later changes do not affect the frame in progress.
- R11: `half_tick` pulses twice per bit period: the first ends the bit's first half and the second ends the bit. A frame lasts 2·(data bits + 2) half ticks from `frame_start`. `ck_out` reacts in the cycle after the tick is sampled. After the last tick the block is idle and accepts a new `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that begins a frame (start bit begins at once) |
| half_tick | input | 1 | Half-bit timing strobe, two per bit period |
| word_nine | input | 1 | 1 = nine data bits, 0 = eight; captured at frame start |
| ck_len_full | input | 1 | 1 = the last data bit is pulsed too; captured at frame start |
| ck_pha | input | 1 | Capture-edge selection (0: first transition, 1: second) |
| ck_pol | input | 1 | Idle level of the clock pin |
| ck_en | input | 1 | 1 = the clock pin toggles; 0 = it holds the idle level |
| ck_out | output | 1 | Clock pin value |
| sample_stb | output | 1 | One-cycle strobe at each capture edge |

## Verification
The edge-coincidence assertion assumes that `ck_pha`, `ck_pol` and `ck_en` do not change in the cycle a strobe appears. The stimulus changes them only between frames. The single-cycle strobe check relies on mid-bit ticks being at least two cycles apart, which follows from the rule that there are two `half_tick` strobes per bit. The bench spaces its ticks between one and four cycles. Extra `frame_start` pulses are sent only as a deliberate mid-frame test.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  typedef enum logic {
    HALF_LEAD  = 1'b0,
    HALF_TRAIL = 1'b1
  } half_e;

  typedef struct packed {
    logic nine;
    logic full_len;
  } frame_cfg_t;
endpackage

// File: rtl/sclk_seq.sv
module sclk_seq
  import sclk_pkg::*;
#(
  parameter int BASE_BITS = 8,
  parameter int STOP_BITS = 1,
  parameter int BIT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             half_tick,
  input  logic             word_nine,
  input  logic             ck_len_full,
  output logic             frame_active,
  output logic [BIT_W-1:0] bit_idx,
  output half_e            half,
  output logic             pulsed_bit,
  output logic             mid_tick
);
  logic             active_q;
  logic [BIT_W-1:0] idx_q;
  half_e            half_q;
  frame_cfg_t       cfg_q;
  logic [BIT_W-1:0] data_n;
  logic [BIT_W-1:0] last_idx;
  logic [BIT_W-1:0] pulse_last;

  // bit 0 is the start bit, 1..data_n are data, then the stop bits
  assign data_n     = BIT_W'(BASE_BITS) + BIT_W'(cfg_q.nine);
  assign last_idx   = data_n + BIT_W'(STOP_BITS);
  assign pulse_last = cfg_q.full_len ? data_n : data_n - BIT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      half_q   <= HALF_LEAD;
      cfg_q    <= '0;
    end else if (!active_q) begin
      if (frame_start) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        half_q   <= HALF_LEAD;
        cfg_q    <= '{nine: word_nine, full_len: ck_len_full};
      end
    end else if (half_tick) begin
      if (half_q == HALF_LEAD) begin
        half_q <= HALF_TRAIL;
      end else begin
        half_q <= HALF_LEAD;
        if (idx_q == last_idx) active_q <= 1'b0;
        else                   idx_q    <= idx_q + BIT_W'(1);
      end
    end
  end

  assign frame_active = active_q;
  assign bit_idx      = idx_q;
  assign half         = half_q;
  assign pulsed_bit   = active_q && (idx_q != '0) && (idx_q <= pulse_last);
  assign mid_tick     = active_q && half_tick && (half_q == HALF_LEAD);
endmodule

// File: rtl/sclk_shape.sv
module sclk_shape
  import sclk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pulsed_bit,
  input  half_e half,
  input  logic  mid_tick,
  input  logic  ck_en,
  input  logic  ck_pha,
  input  logic  ck_pol,
  output logic  ck_out,
  output logic  sample_stb
);
  logic active_level;
  logic stb_q;

  // phase 0: second half active; phase 1: first half active
  assign active_level = pulsed_bit && ((half == HALF_TRAIL) != ck_pha);
  assign ck_out       = ck_pol ^ (ck_en & active_level);

  always_ff @(posedge clk) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= ck_en && mid_tick && pulsed_bit;
  end

  assign sample_stb = stb_q;
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int BASE_BITS = 8,
  parameter int STOP_BITS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic half_tick,
  input  logic word_nine,
  input  logic ck_len_full,
  input  logic ck_pha,
  input  logic ck_pol,
  input  logic ck_en,
  output logic ck_out,
  output logic sample_stb
);
  localparam int MAX_IDX = BASE_BITS + 1 + STOP_BITS;
  localparam int BIT_W   = $clog2(MAX_IDX + 1);

  logic             frame_active;
  logic [BIT_W-1:0] bit_idx;
  sclk_pkg::half_e  half;
  logic             pulsed_bit;
  logic             mid_tick;

  sclk_seq #(
    .BASE_BITS(BASE_BITS),
    .STOP_BITS(STOP_BITS),
    .BIT_W    (BIT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .half_tick   (half_tick),
    .word_nine   (word_nine),
    .ck_len_full (ck_len_full),
    .frame_active(frame_active),
    .bit_idx     (bit_idx),
    .half        (half),
    .pulsed_bit  (pulsed_bit),
    .mid_tick    (mid_tick)
  );

  sclk_shape u_shape (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulsed_bit(pulsed_bit),
    .half      (half),
    .mid_tick  (mid_tick),
    .ck_en     (ck_en),
    .ck_pha    (ck_pha),
    .ck_pol    (ck_pol),
    .ck_out    (ck_out),
    .sample_stb(sample_stb)
  );
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk #(
  parameter int BIT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             half_tick,
  input logic             ck_pha,
  input logic             ck_pol,
  input logic             ck_en,
  input logic             ck_out,
  input logic             sample_stb,
  input logic             frame_active,
  input logic [BIT_W-1:0] bit_idx
);
  // R9: the strobe never lasts two cycles
  a_r9_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R9: the strobe coincides with a transition of the pin
  a_r9_stb_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && $stable(ck_pha) && $stable(ck_pol) && $stable(ck_en))
      |-> (ck_out != $past(ck_out)));

  // R4: the start bit opens at the idle level
  a_r4_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active) |-> (ck_out == ck_pol));

  // R1: no strobe outside a frame
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |-> !sample_stb);

  // R8: disabled clock gives no strobes
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ck_en && $past(!ck_en)) |-> !sample_stb);

  // R10: a start pulse inside a frame does not move the bit position
  a_r10_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && frame_start && !half_tick) |=> $stable(bit_idx));
endmodule

bind sclk_gen sclk_gen_chk #(.BIT_W(BIT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .half_tick   (half_tick),
  .ck_pha      (ck_pha),
  .ck_pol      (ck_pol),
  .ck_en       (ck_en),
  .ck_out      (ck_out),
  .sample_stb  (sample_stb),
  .frame_active(frame_active),
  .bit_idx     (bit_idx)
);

// File: tb/sclk_gen_test.sv
module sclk_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic half_tick = 1'b0;
  logic word_nine = 1'b0;
  logic ck_len_full = 1'b0;
  logic ck_pha = 1'b0;
  logic ck_pol = 1'b0;
  logic ck_en = 1'b0;
  logic ck_out;
  logic sample_stb;

  int checks = 0;
  int fails = 0;
  int tick_gap = 2;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sclk_gen uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .half_tick  (half_tick),
    .word_nine  (word_nine),
    .ck_len_full(ck_len_full),
    .ck_pha     (ck_pha),
    .ck_pol     (ck_pol),
    .ck_en      (ck_en),
    .ck_out     (ck_out),
    .sample_stb (sample_stb)
  );

  // behavioural reference: half count since frame start
  int  m_act = 0;
  int  m_h = 0;
  int  m_n = 8;
  int  m_full = 0;
  bit  m_stb = 1'b0;

  function automatic bit pulsed(int b, int n, int full);
    return (b >= 1) && (b <= n - 1 + full);
  endfunction

  always @(posedge clk) begin
    bit nxt;
    if (!rst_n) begin
      m_act = 0; m_h = 0; m_stb = 1'b0;
    end else begin
      nxt = ck_en && (m_act != 0) && half_tick && (m_h % 2 == 0)
            && pulsed(m_h / 2, m_n, m_full);
      if (m_act == 0) begin
        if (frame_start) begin
          m_act = 1; m_h = 0; m_n = word_nine ? 9 : 8; m_full = ck_len_full;
        end
      end else if (half_tick) begin
        if (m_h == 2 * (m_n + 2) - 1) m_act = 0;
        else m_h = m_h + 1;
      end
      m_stb = nxt;
    end
  end

  // per-cycle comparison plus pulse bookkeeping
  int  pulse_cnt = 0;
  int  stb_cnt = 0;
  int  outside_cnt = 0;
  bit  prev_ck = 1'b0;

  always @(posedge clk) begin
    bit lvl;
    bit exp_ck;
    #2;
    if (rst_n && !done) begin
      lvl = (m_act != 0) && pulsed(m_h / 2, m_n, m_full) && (((m_h % 2) == 1) != ck_pha);
      exp_ck = ck_pol ^ (ck_en & lvl);
      checks++;
      if (ck_out !== exp_ck) begin
        fails++;
        $display("FAIL R4 R5 R6 R7 R11 ck_out at %0t: actual=%0b expected=%0b", $time, ck_out, exp_ck);
      end
      checks++;
      if (sample_stb !== m_stb) begin
        fails++;
        $display("FAIL R9 sample_stb at %0t: actual=%0b expected=%0b", $time, sample_stb, m_stb);
      end
      if (ck_out != ck_pol && prev_ck == ck_pol) pulse_cnt++;
      if (sample_stb) stb_cnt++;
      if (m_act != 0 && ck_out != ck_pol && (m_h / 2 == 0 || m_h / 2 > m_n)) outside_cnt++;
      prev_ck = ck_out;
    end
  end

  // half-bit strobe source
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (cnt >= tick_gap - 1) begin half_tick = 1'b1; cnt = 0; end
      else begin half_tick = 1'b0; cnt++; end
    end
  end

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_frame(bit nine, bit full, bit pha, bit pol, bit en, int gap,
                           int exp_pulses, string tag, bit disturb);
    @(negedge clk);
    word_nine = nine; ck_len_full = full; ck_pha = pha; ck_pol = pol; ck_en = en;
    tick_gap = gap;
    @(negedge clk);
    pulse_cnt = 0; stb_cnt = 0; outside_cnt = 0; prev_ck = pol;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    if (disturb) begin
      repeat (20) @(negedge clk);
      word_nine = ~nine; ck_len_full = ~full;
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
    end
    wait (m_act == 0);
    repeat (4) @(negedge clk);
    check_eq({tag, " pulse count"}, pulse_cnt, exp_pulses);
    check_eq("R9 strobe count", stb_cnt, en ? exp_pulses : 0);
    check_eq("R4 active level outside data bits", outside_cnt, 0);
    check_eq("R1 idle level after frame", int'(ck_out), int'(pol));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R1 reset ck_out", int'(ck_out), 0);
    check_eq("R1 reset sample_stb", int'(sample_stb), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3, 7, "R2 R5 8-bit short", 1'b0);
    run_frame(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2, 8, "R2 R6 9-bit short", 1'b0);
    run_frame(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1, 8, "R3 R7 8-bit full", 1'b0);
    run_frame(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4, 9, "R3 R7 9-bit full", 1'b0);
    run_frame(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2, 0, "R8 disabled", 1'b0);
    run_frame(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2, 8, "R10 restart ignored", 1'b1);
    run_frame(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1, 7, "R11 back-to-back", 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R11 watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule